// File: doc/BRIEF.md
# Temperature Offset and Format Converter

This block turns an internal 16-bit temperature word into the value that is handed back to a host. The input word is two's complement fixed point, with the 1°C weight at bit 6. That gives a resolution of 1/64°C and a span of -512°C to just under +512°C. A reading is often relative to a trip point. To turn it into an absolute temperature, an optional programmable offset is added. The result may then be packed into a compact integer-degree form, in which the low byte alone holds the signed temperature.

Words from 8000h to 81FFh are status codes, not temperatures. They leave the block exactly as they came in. The offset is supplied in whichever format is currently selected, and the block scales it to the internal fixed point. A stored offset therefore names the same temperature in either format: +95°C is 17C0h in full format and 005Fh in integer format.

All arithmetic is combinational and is followed by a single output register. A result appears one clock after its input is marked valid.

Top module: `tc_fmt_conv`

## Requirements
- R1: Any input word whose top seven bits are 1000000b (8000h through 81FFh) is output unchanged, whatever the offset, offset enable and format inputs are; 7FFFh and 8200h are treated as temperatures.
- R2: In full format (fmt_int_i = 0) with offset_en_i = 1, a temperature word is output as temp_i + offset_i.
- R3: With offset_en_i = 0, a temperature word in full format is output equal to temp_i, and offset_i has no effect.
- R4: With fmt_int_i = 1, the output takes the corrected word s and places s[15] in each of bits 15:8. Bits 7:0 are {s[15], s[12:6]}, so the low byte is the signed whole-degree value from -128 to +127.
- R5: With fmt_int_i = 1, offset_i counts whole degrees and is scaled to offset_i shifted left by 6 before the addition. So 005Fh in integer format and 17C0h in full format add the same +95°C.
- R6: res_valid_o equals temp_valid_i delayed by exactly one clock.
- R7: While temp_valid_i is low, res_o keeps its last value.
- R8: During reset, res_o is 0000h and res_valid_o is 0.
- R9: The offset addition wraps modulo 2^16 with no saturation (7FC0h + 0080h gives 8040h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_valid_i | input | 1 | temp_i carries a new word |
| temp_i | input | 16 | Internal temperature word or status code |
| offset_en_i | input | 1 | Add the offset to temperature words |
| fmt_int_i | input | 1 | 1 selects the integer-degree output format |
| offset_i | input | 16 | Offset, expressed in the selected format |
| res_valid_o | output | 1 | res_o was updated in this cycle |
| res_o | output | 16 | Converted result |

## Verification
The properties assume that the format select and the offset inputs are steady in the cycle in which a word is accepted. They also assume that temp_valid_i is driven to a known level from reset onward. The bench changes every input only at the falling clock edge and pulses temp_valid_i for one cycle per vector, so each accepted word sees a consistent configuration. Status words, near-boundary temperatures and wrapping sums come from the vector table. The directed tests cover the idle-hold and latency behaviour.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned TC_DATA_W = 16;
  localparam int unsigned TC_FRAC_W = 6;
  localparam int unsigned TC_BYTE_W = 8;
  localparam int unsigned TC_ERR_LSB = 9;

  typedef enum logic {
    FMT_FULL = 1'b0,
    FMT_INT  = 1'b1
  } fmt_e;
endpackage

// File: rtl/tc_err_detect.sv
module tc_err_detect #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ERR_LSB = 9,
  parameter logic [DATA_W-ERR_LSB-1:0] ERR_TAG = 7'h40
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              is_err_o
);
  assign is_err_o = (word_i[DATA_W-1:ERR_LSB] == ERR_TAG);
endmodule

// File: rtl/tc_offset_scale.sv
module tc_offset_scale #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic [DATA_W-1:0] offset_i,
  input  tc_pkg::fmt_e      fmt_i,
  output logic [DATA_W-1:0] offset_fp_o
);
  // integer-degree offsets are moved up to the fixed-point degree bit
  always_comb begin
    if (fmt_i == tc_pkg::FMT_INT) offset_fp_o = offset_i << FRAC_W;
    else                          offset_fp_o = offset_i;
  end
endmodule

// File: rtl/tc_alt_pack.sv
module tc_alt_pack #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] packed_o
);
  localparam int unsigned MAG_W = BYTE_W - 1;

  for (genvar i = BYTE_W; i < DATA_W; i++) begin : g_sign_ext
    assign packed_o[i] = val_i[DATA_W-1];
  end
  assign packed_o[BYTE_W-1]  = val_i[DATA_W-1];
  assign packed_o[MAG_W-1:0] = val_i[FRAC_W+MAG_W-1:FRAC_W];
endmodule

// File: rtl/tc_fmt_conv.sv
module tc_fmt_conv #(
  parameter int unsigned DATA_W = tc_pkg::TC_DATA_W,
  parameter int unsigned FRAC_W = tc_pkg::TC_FRAC_W,
  parameter int unsigned BYTE_W = tc_pkg::TC_BYTE_W,
  parameter int unsigned ERR_LSB = tc_pkg::TC_ERR_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_valid_i,
  input  logic [DATA_W-1:0] temp_i,
  input  logic              offset_en_i,
  input  logic              fmt_int_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned TAG_W = DATA_W - ERR_LSB;
  localparam logic [TAG_W-1:0] ERR_TAG = {1'b1, {(TAG_W-1){1'b0}}};

  tc_pkg::fmt_e      fmt;
  logic              is_err;
  logic [DATA_W-1:0] offset_fp;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] packed_w;
  logic [DATA_W-1:0] res_d;

  assign fmt = fmt_int_i ? tc_pkg::FMT_INT : tc_pkg::FMT_FULL;

  tc_err_detect #(.DATA_W(DATA_W), .ERR_LSB(ERR_LSB), .ERR_TAG(ERR_TAG)) u_err (
    .word_i  (temp_i),
    .is_err_o(is_err)
  );

  tc_offset_scale #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_scale (
    .offset_i   (offset_i),
    .fmt_i      (fmt),
    .offset_fp_o(offset_fp)
  );

  // modulo 2^DATA_W, no saturation
  assign sum = temp_i + (offset_en_i ? offset_fp : '0);

  tc_alt_pack #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .BYTE_W(BYTE_W)) u_pack (
    .val_i   (sum),
    .packed_o(packed_w)
  );

  always_comb begin
    if (is_err)                       res_d = temp_i;
    else if (fmt == tc_pkg::FMT_INT)  res_d = packed_w;
    else                              res_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= temp_valid_i;
      if (temp_valid_i) res_o <= res_d;
    end
  end

  assert_err_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_valid_i && is_err) |=> (res_o == $past(temp_i)));

  assert_int_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_valid_i && fmt_int_i && !is_err) |=> (res_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){res_o[BYTE_W-1]}}));

  assert_valid_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temp_valid_i |=> res_valid_o);

  assert_valid_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_valid_i |=> !res_valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_valid_i |=> $stable(res_o));

  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_valid_i && !offset_en_i && !fmt_int_i) |=> (res_o == $past(temp_i)));
endmodule

// File: tb/tc_fmt_conv_tb.sv
module tc_fmt_conv_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        temp_valid_i = 1'b0;
  logic [15:0] temp_i = '0;
  logic        offset_en_i = 1'b0;
  logic        fmt_int_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic        res_valid_o;
  logic [15:0] res_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  tc_fmt_conv u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .temp_valid_i(temp_valid_i), .temp_i(temp_i),
    .offset_en_i(offset_en_i), .fmt_int_i(fmt_int_i), .offset_i(offset_i),
    .res_valid_o(res_valid_o), .res_o(res_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] temp;
    logic [15:0] off;
    logic        en;
    logic        alt;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 16'hFFC0, 16'h17C0, 1'b1, 1'b0, 16'h1780}, // R2 -1 + 95
    '{8'd2, 16'h0640, 16'h0C80, 1'b1, 1'b0, 16'h12C0}, // R2 25 + 50
    '{8'd5, 16'hFFC0, 16'h005F, 1'b1, 1'b1, 16'h005E}, // R5 int offset
    '{8'd5, 16'h0000, 16'h005F, 1'b1, 1'b1, 16'h005F}, // R5
    '{8'd5, 16'h0640, 16'hFFFF, 1'b1, 1'b1, 16'h0018}, // R5 -1 deg
    '{8'd4, 16'hF380, 16'h0000, 1'b0, 1'b1, 16'hFFCE}, // R4 -50
    '{8'd4, 16'hED40, 16'h1234, 1'b0, 1'b1, 16'hFFB5}, // R4 -75
    '{8'd4, 16'h1FC0, 16'h0000, 1'b0, 1'b1, 16'h007F}, // R4 +127
    '{8'd1, 16'h8000, 16'h17C0, 1'b1, 1'b1, 16'h8000}, // R1 low edge
    '{8'd1, 16'h81FF, 16'h17C0, 1'b1, 1'b0, 16'h81FF}, // R1 high edge
    '{8'd1, 16'h8123, 16'h0001, 1'b1, 1'b1, 16'h8123}, // R1 int fmt
    '{8'd1, 16'h8200, 16'h0040, 1'b1, 1'b0, 16'h8240}, // R1 just above
    '{8'd9, 16'h7FFF, 16'h0001, 1'b1, 1'b0, 16'h8000}, // R9 wrap, R1 below
    '{8'd9, 16'h7FC0, 16'h0080, 1'b1, 1'b0, 16'h8040}, // R9
    '{8'd3, 16'hFD80, 16'h17C0, 1'b0, 1'b0, 16'hFD80}, // R3
    '{8'd3, 16'h0001, 16'hFFFF, 1'b0, 1'b0, 16'h0001}  // R3
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] t, input logic [15:0] o, input logic en, input logic alt);
    @(negedge clk_i);
    temp_i = t; offset_i = o; offset_en_i = en; fmt_int_i = alt; temp_valid_i = 1'b1;
    @(negedge clk_i);
    temp_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8 res_o", res_o, 16'h0000);
    check("R8 res_valid_o", {15'd0, res_valid_o}, 16'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].temp, VECS[i].off, VECS[i].en, VECS[i].alt);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), res_o, VECS[i].exp);
    end

    // R6 latency: valid appears one edge later, gone one edge after drop
    @(negedge clk_i);
    temp_i = 16'h0640; offset_en_i = 1'b0; fmt_int_i = 1'b0; temp_valid_i = 1'b1;
    check("R6 before edge", {15'd0, res_valid_o}, 16'd0);
    @(negedge clk_i);
    check("R6 after edge", {15'd0, res_valid_o}, 16'd1);
    check("R6 data", res_o, 16'h0640);
    temp_valid_i = 1'b0;
    @(negedge clk_i);
    check("R6 drop", {15'd0, res_valid_o}, 16'd0);

    // R7 hold while idle with changing inputs
    temp_i = 16'h1234; offset_en_i = 1'b1; offset_i = 16'h0100;
    @(negedge clk_i);
    fmt_int_i = 1'b1; temp_i = 16'h8001;
    @(negedge clk_i);
    check("R7 hold", res_o, 16'h0640);

    // R8 asynchronous reset mid-run
    #3 rst_ni = 1'b0;
    #2;
    check("R8 async res_o", res_o, 16'h0000);
    check("R8 async valid", {15'd0, res_valid_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule